// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 41 level-sensitive interrupt request lines from peripherals and gives the processor one 3-bit encoded request level. That level belongs to the single most urgent pending source. Each source has a control register with three fields: an individual mask bit, a 3-bit level and a 3-bit sub-priority that ranks sources sharing the same level. A global mask-all bit silences every source at once.

Sources 0 to 33 are fully programmable. Sources 34 to 40 have a level and a sub-priority wired in hardware, and software can change only their mask bit. Arbitration has two tiers. The highest level wins. Among sources at that level, the highest sub-priority wins. If both are equal, the lowest index wins.

The processor can learn which source won in two ways. It can issue a hardware acknowledge, which names a level. It can also do a software acknowledge, which is a register read. Either way the block returns the winner's vector number and leaves the source pending. A wake output tells the power controller that an unmasked request is waiting.

The acknowledge and read responses are valid-only streams. Each request gets exactly one response-valid pulse on the following cycle. There is no ready signal, because the requester must accept the response when it arrives.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_level is 0 and wake is 0. Every source's mask bit (control bit 6) is 1. The global mask (address 126, bit 0) is 0. Programmable sources read level 0 and sub-priority 0.
- R2: One clock edge after the inputs change, irq_level equals the highest level among eligible sources, or 0 if none is eligible. A source is eligible when its request is high, it is unmasked, the global mask is clear and its level is nonzero.
- R3: A source whose level field (control bits 5:3) is 0 never takes part in arbitration, even when it is unmasked and requesting.
- R4: Among eligible sources at the winning level, the higher sub-priority (control bits 2:0) wins. If sub-priorities are also equal, the lower source index wins.
- R5: Setting a source's mask bit removes it from arbitration.
- R6: While the global mask bit is 1, irq_level and wake go to 0 and both acknowledge paths return the spurious vector.
- R7: Source i, for i from 34 to 40, has a fixed level of i-33 and a fixed sub-priority of 7. Writes change only its mask bit, and its control register reads back the fixed fields.
- R8: The vector for source i is 64+i. When nothing qualifies, the spurious vector 0xFF is returned.
- R9: A read of address 127 returns the current winner's vector in rd_data, with rd_valid high on the next cycle. The read does not clear or change any pending request. Control registers live at addresses 0 to 40.
- R10: When hw_ack_valid is high with level L, the next cycle shows hw_ack_rsp_valid high and hw_ack_vector set to the vector of the best eligible source at exactly level L, or 0xFF.
- R11: wake is registered alongside irq_level and is 1 exactly when some source is eligible.
- R12: Requests are not latched. When a request line drops, its effect on irq_level disappears after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 41 | Level-sensitive request lines, one per source |
| cfg_addr | input | 7 | Register address for writes and reads |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| rd_en | input | 1 | Register read request |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| rd_data | output | 8 | Read response data |
| hw_ack_valid | input | 1 | Hardware acknowledge request |
| hw_ack_level | input | 3 | Level being acknowledged |
| hw_ack_rsp_valid | output | 1 | Hardware acknowledge response valid |
| hw_ack_vector | output | 8 | Vector returned for the acknowledge |
| irq_level | output | 3 | Registered encoded request level to the core |
| wake | output | 1 | Registered wake-up indication |

## Verification
On every cycle, the assertions check these relations:
- wake always agrees with a nonzero irq_level.
- The global mask forces both outputs to 0 one cycle later.
- Idle request lines force a 0 level.
- Every read and acknowledge request gets its response one cycle later.
- Any non-spurious vector lies in the source range.

Only the bench scenarios can show which source actually wins. Those scenarios cover sub-priority ties, index ties, level-0 exclusion, per-source masking, the write-protected fixed sources, and the fact that an acknowledge leaves the request pending. The bench checks each of these against a behavioural model of the control registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC       = 41;
  localparam int NFIXED     = 7;
  localparam int LVLW       = 3;
  localparam int PRIW       = 3;
  localparam int VECW       = 8;
  localparam int VEC_BASE   = 64;
  localparam int ADDRW      = 7;
  localparam int DATAW      = 8;
  localparam int GCTL_ADDR  = 126;
  localparam int SWACK_ADDR = 127;

  typedef struct packed {
    logic            mask;
    logic [LVLW-1:0] lvl;
    logic [PRIW-1:0] pri;
  } src_ctrl_t;

  localparam int CTRLW = $bits(src_ctrl_t);
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC   = NSRC,
  parameter int N_FIXED = NFIXED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ADDRW-1:0] addr,
  input  logic [DATAW-1:0] wdata,
  output src_ctrl_t        ctrl_o [N_SRC],
  output logic             gmask_o
);
  localparam int NPROG = N_SRC - N_FIXED;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATAW-1:CTRLW];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i < NPROG) begin : g_prog
      src_ctrl_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= src_ctrl_t'{mask: 1'b1, lvl: '0, pri: '0};
        else if (we && addr == ADDRW'(i))
          q <= src_ctrl_t'(wdata[CTRLW-1:0]);
      end
      assign ctrl_o[i] = q;
    end else begin : g_fix
      logic mask_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          mask_q <= 1'b1;
        else if (we && addr == ADDRW'(i))
          mask_q <= wdata[CTRLW-1];
      end
      assign ctrl_o[i] = src_ctrl_t'{mask: mask_q, lvl: LVLW'(i - NPROG + 1), pri: '1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gmask_o <= 1'b0;
    else if (we && addr == ADDRW'(GCTL_ADDR))
      gmask_o <= wdata[0];
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int N_SRC = NSRC,
  localparam int IDXW = $clog2(N_SRC)
) (
  input  src_ctrl_t        ctrl [N_SRC],
  input  logic             gmask,
  input  logic [N_SRC-1:0] req,
  input  logic             flt_en,
  input  logic [LVLW-1:0]  flt_lvl,
  output logic             win_valid,
  output logic [LVLW-1:0]  win_lvl,
  output logic [IDXW-1:0]  win_idx
);
  logic [LVLW+PRIW-1:0] best_key;

  always_comb begin
    win_valid = 1'b0;
    best_key  = '0;
    win_idx   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      logic elig;
      elig = req[i] && !ctrl[i].mask && !gmask && (ctrl[i].lvl != '0) &&
             (!flt_en || ctrl[i].lvl == flt_lvl);
      // strict compare keeps the lower index on an exact tie
      if (elig && (!win_valid || {ctrl[i].lvl, ctrl[i].pri} > best_key)) begin
        win_valid = 1'b1;
        best_key  = {ctrl[i].lvl, ctrl[i].pri};
        win_idx   = IDXW'(i);
      end
    end
    win_lvl = best_key[LVLW+PRIW-1:PRIW];
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_src,
  input  logic [ADDRW-1:0] cfg_addr,
  input  logic             cfg_we,
  input  logic [DATAW-1:0] cfg_wdata,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [DATAW-1:0] rd_data,
  input  logic             hw_ack_valid,
  input  logic [LVLW-1:0]  hw_ack_level,
  output logic             hw_ack_rsp_valid,
  output logic [VECW-1:0]  hw_ack_vector,
  output logic [LVLW-1:0]  irq_level,
  output logic             wake
);
  localparam int IDXW = $clog2(NSRC);

  src_ctrl_t       ctrl [NSRC];
  logic            gmask;
  logic            main_valid, ack_valid;
  logic [LVLW-1:0] main_lvl, unused_ack_lvl;
  logic [IDXW-1:0] main_idx, ack_idx;
  logic [VECW-1:0] sw_vec, ack_vec;
  logic [DATAW-1:0] rd_mux;

  irqc_regs #(.N_SRC(NSRC), .N_FIXED(NFIXED)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .ctrl_o(ctrl), .gmask_o(gmask)
  );

  irqc_arb #(.N_SRC(NSRC)) u_arb_main (
    .ctrl(ctrl), .gmask(gmask), .req(irq_src), .flt_en(1'b0),
    .flt_lvl('0), .win_valid(main_valid), .win_lvl(main_lvl), .win_idx(main_idx)
  );

  irqc_arb #(.N_SRC(NSRC)) u_arb_ack (
    .ctrl(ctrl), .gmask(gmask), .req(irq_src), .flt_en(1'b1),
    .flt_lvl(hw_ack_level), .win_valid(ack_valid), .win_lvl(unused_ack_lvl),
    .win_idx(ack_idx)
  );

  assign sw_vec  = main_valid ? VECW'(VEC_BASE + int'(main_idx)) : '1;
  assign ack_vec = ack_valid  ? VECW'(VEC_BASE + int'(ack_idx))  : '1;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSRC; i++)
      if (cfg_addr == ADDRW'(i)) rd_mux = DATAW'(ctrl[i]);
    if (cfg_addr == ADDRW'(GCTL_ADDR))  rd_mux = DATAW'(gmask);
    if (cfg_addr == ADDRW'(SWACK_ADDR)) rd_mux = DATAW'(sw_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level        <= '0;
      wake             <= 1'b0;
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      hw_ack_rsp_valid <= 1'b0;
      hw_ack_vector    <= '0;
    end else begin
      irq_level        <= main_valid ? main_lvl : '0;
      wake             <= main_valid;
      rd_valid         <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      hw_ack_rsp_valid <= hw_ack_valid;
      if (hw_ack_valid) hw_ack_vector <= ack_vec;
    end
  end

  // R6
  gmask_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> (irq_level == '0 && !wake));
  // R11
  wake_level_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (irq_level != '0));
  // R12
  idle_lines_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0) |=> (irq_level == '0));
  // R9
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R10
  ack_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack_valid |=> hw_ack_rsp_valid);
  // R8
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_ack_rsp_valid && hw_ack_vector != '1) |->
      (hw_ack_vector >= VECW'(VEC_BASE) && hw_ack_vector < VECW'(VEC_BASE + NSRC)));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int N = 41;
  localparam int NP = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic [6:0] cfg_addr = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic rd_en = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic hw_ack_valid = 1'b0;
  logic [2:0] hw_ack_level = '0;
  logic hw_ack_rsp_valid;
  logic [7:0] hw_ack_vector;
  logic [2:0] irq_level;
  logic wake;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_addr(cfg_addr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .hw_ack_valid(hw_ack_valid), .hw_ack_level(hw_ack_level),
    .hw_ack_rsp_valid(hw_ack_rsp_valid), .hw_ack_vector(hw_ack_vector),
    .irq_level(irq_level), .wake(wake)
  );

  int n_checks = 0;
  int n_fails = 0;

  // behavioural model of the control state, built from the requirements
  int m_lvl [N];
  int m_pri [N];
  bit m_msk [N];
  bit m_gm;

  logic [7:0] exp_q [$];
  string      req_q [$];

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_win(bit flt, int fl);
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (irq_src[i] && !m_msk[i] && !m_gm && m_lvl[i] != 0 && (!flt || m_lvl[i] == fl)) begin
        if (best < 0 || m_lvl[i] > m_lvl[best] ||
            (m_lvl[i] == m_lvl[best] && m_pri[i] > m_pri[best]))
          best = i;
      end
    end
    return best;
  endfunction

  function automatic int vec_of(int idx);
    return (idx < 0) ? 255 : 64 + idx;
  endfunction

  function automatic int model_reg(int a);
    if (a < N) return (m_msk[a] ? 64 : 0) + m_lvl[a] * 8 + m_pri[a];
    if (a == 126) return int'(m_gm);
    if (a == 127) return vec_of(model_win(1'b0, 0));
    return 0;
  endfunction

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 8'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < NP) begin
      m_msk[a] = d[6]; m_lvl[a] = (d >> 3) & 7; m_pri[a] = d & 7;
    end else if (a < N) begin
      m_msk[a] = d[6];
    end else if (a == 126) begin
      m_gm = d[0];
    end
  endtask

  // driver: push the expected item then issue the request
  task automatic rd(int a, string req);
    @(posedge clk); #1;
    exp_q.push_back(8'(model_reg(a))); req_q.push_back(req);
    rd_en = 1'b1; cfg_addr = 7'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic hw_ack(int lvl, string req);
    @(posedge clk); #1;
    exp_q.push_back(8'(vec_of(model_win(1'b1, lvl)))); req_q.push_back(req);
    hw_ack_valid = 1'b1; hw_ack_level = 3'(lvl);
    @(posedge clk); #1;
    hw_ack_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle_check(string req);
    int w;
    repeat (2) @(posedge clk);
    @(negedge clk);
    w = model_win(1'b0, 0);
    check({req, " level"}, int'(irq_level), (w < 0) ? 0 : m_lvl[w]);
    check({req, " wake"}, int'(wake), (w < 0) ? 0 : 1);
  endtask

  task automatic set_src(int i, bit v);
    @(posedge clk); #1;
    irq_src[i] = v;
  endtask

  // monitor: pop and compare each response as it appears
  always @(negedge clk) begin
    if (rst_n && (rd_valid || hw_ack_rsp_valid)) begin
      if (exp_q.size() == 0) begin
        check("R9/R10 unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, rd_valid ? int'(rd_data) : int'(hw_ack_vector), int'(e));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_msk[i] = 1'b1;
      m_lvl[i] = (i >= NP) ? i - 33 : 0;
      m_pri[i] = (i >= NP) ? 7 : 0;
    end
    m_gm = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", int'(irq_level), 0);
    check("R1 wake", int'(wake), 0);
    rd(0, "R1 ctrl0");
    rd(40, "R1 R7 ctrl40");
    rd(126, "R1 gmask");
    rd(127, "R1 R8 spurious");

    // R2 single source
    wr(3, 8'h11);
    set_src(3, 1'b1);
    settle_check("R2 src3");
    rd(127, "R9 R8 vec src3");

    wr(10, 8'h28);
    set_src(10, 1'b1);
    settle_check("R2 src10");
    rd(127, "R2 vec src10");

    // R4 sub-priority
    wr(12, 8'h2C);
    set_src(12, 1'b1);
    rd(127, "R4 prio src12");

    // R4 index tie
    wr(11, 8'h2C);
    set_src(11, 1'b1);
    rd(127, "R4 tie src11");
    rd(127, "R9 no clear");
    settle_check("R9 still pending");

    // R10 hardware acknowledge
    hw_ack(2, "R10 lvl2");
    hw_ack(6, "R10 lvl6 spurious");
    hw_ack(5, "R10 lvl5");
    settle_check("R10 no clear");

    // R5 mask
    wr(11, 8'h6C);
    rd(127, "R5 masked src11");
    rd(11, "R5 ctrl11");

    // R3 level zero
    for (int i = 3; i <= 12; i++) irq_src[i] = 1'b0;
    wr(20, 8'h05);
    set_src(20, 1'b1);
    settle_check("R3 level0");
    rd(127, "R3 spurious");

    // R7 fixed source
    wr(40, 8'h00);
    rd(40, "R7 fixed readback");
    set_src(40, 1'b1);
    set_src(35, 1'b1);
    wr(35, 8'h00);
    settle_check("R7 src40");
    rd(127, "R7 vec40");
    hw_ack(2, "R7 R10 src35");
    set_src(3, 1'b1);
    settle_check("R11 wake");

    // R6 global mask
    wr(126, 1);
    settle_check("R6 gmask");
    rd(127, "R6 sw spurious");
    hw_ack(7, "R6 hw spurious");
    rd(126, "R6 gmask readback");
    wr(126, 0);
    settle_check("R6 release");

    // R12 not latched
    set_src(40, 1'b0);
    settle_check("R12 drop40");
    set_src(35, 1'b0);
    set_src(3, 1'b0);
    settle_check("R12 drop all");

    repeat (4) @(posedge clk);
    check("R9 R10 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule